// File: doc/BRIEF.md
# I2C Register-Access Transaction Sequencer

This block is the master-side sequencer for complete I2C register reads and writes. It accepts one request at a time. A request holds the direction, an 8-bit device byte, a sub-address of up to four bytes with its length, a byte count and an immediate data byte. The sequencer turns the request into a series of byte-level bus operations: START, repeated START, write byte, read with ACK, read with NACK, and STOP. It hands these operations one at a time to a bit phase engine outside the block. The engine returns completion, the slave's acknowledge and the received bytes.

Write data enters on a valid/ready byte stream. Read data leaves on another. Any NACK from the slave ends the transfer with a STOP and raises the error flag. The block contains the tick divider that paces the engine. The divider runs only while a transaction is in progress.

Top module: `i2c_reg_sequencer`

## Requirements
- R1: `req_taken` is high exactly when `req_valid` is high and `busy` is low, and `busy` rises on the next cycle. A request presented while `busy` is high is not taken and does not change the running transfer.
- R2: Operations use the code field `op_code` with these values: 1 = START, 2 = repeated START, 3 = write byte (`op_byte`), 4 = read and ACK, 5 = read and NACK, 6 = STOP. Every transaction opens with START, followed by a write of the device byte with bit 0 forced to 0.
- R3: With a sub-address length L of 1 to 4, L write operations follow, carrying the low L bytes of `req_sub` most significant first. Length 0 sends none. Lengths 5 to 7 behave as 4.
- R4: A read continues after the sub-address phase with a repeated START and then a write of the device byte with bit 0 forced to 1.
- R5: A read of N bytes issues N-1 read-and-ACK operations and then one read-and-NACK, then STOP. A count of 0 reads one byte. Each received byte is presented on `rd_data` with `rd_valid` in order, and is held until `rd_ready`.
- R6: A write with count 0 sends `req_imm` as a single data byte, then STOP.
- R7: A write with count N > 0 takes N bytes from the write stream in order and sends each one. The sequencer waits with `wr_ready` high, and issues no operation, until `wr_valid` is seen.
- R8: A NACK on the device byte, a sub-address byte or a write data byte is followed directly by STOP. When that STOP completes, `error` is set and `err_pulse` is high for one cycle.
- R9: On normal completion `busy` and `error` go low. In the same cycle, `rx_done` (read) or `tx_done` (write) is high for one cycle. At most one of the three end pulses is high at a time.
- R10: `bus_tick` pulses once every TICK_DIV cycles while `tick_run` is high. `tick_run` follows `busy`. No tick occurs while idle.
- R11: `op_valid` is high only while busy. Once raised, it holds with a stable code and byte until `op_done`.
- R12: Accepting a new request clears `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1 = read, 0 = write |
| req_dev | input | 8 | Device byte (bit 0 is overridden) |
| req_sub | input | 32 | Sub-address, right-aligned |
| req_sub_len | input | 3 | Sub-address byte count, 0 to 4 |
| req_count | input | 8 | Data byte count |
| req_imm | input | 8 | Immediate byte for count-0 writes |
| req_taken | output | 1 | Request accepted this cycle |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte valid |
| wr_ready | output | 1 | Sequencer waiting for a write byte |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte valid |
| rd_ready | input | 1 | Read stream consumer ready |
| tick_run | output | 1 | Tick divider enabled |
| bus_tick | output | 1 | Pacing tick for the bit engine |
| op_valid | output | 1 | Operation requested from the engine |
| op_code | output | 3 | Operation code (see R2) |
| op_byte | output | 8 | Byte for write operations |
| op_done | input | 1 | Engine finished the operation |
| op_nack | input | 1 | Slave did not acknowledge the written byte |
| op_rdata | input | 8 | Byte received by a read operation |
| busy | output | 1 | Transaction in progress |
| error | output | 1 | Last transaction aborted on NACK |
| tx_done | output | 1 | Write completed normally |
| rx_done | output | 1 | Read completed normally |
| err_pulse | output | 1 | Transaction aborted |

## Verification
The bench sweeps both directions over every sub-address length from 0 to 4, plus one oversize length, and over counts 0 to 3 and one longer count. The rows with count 0 separate the immediate write mode from the streamed mode, and the read rows check that count 0 reads a single byte. The sub-address value has distinct bytes, so a wrong byte order or a wrong number of bytes changes the logged operation list. Half of the runs throttle both data streams to show that stalls change only the timing. A second sweep injects a NACK on each write position in turn: device, every sub-address byte, the read device byte, and every data byte. Each case must truncate the operation list to exactly one STOP and must give the error pulse instead of a done pulse.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_RESTART = 3'd2,
        OP_WRITE   = 3'd3,
        OP_RD_ACK  = 3'd4,
        OP_RD_NACK = 3'd5,
        OP_STOP    = 3'd6
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_DEV_WR,
        S_SUB,
        S_RESTART,
        S_DEV_RD,
        S_RD,
        S_RD_PUSH,
        S_WR_FETCH,
        S_WR_DATA,
        S_WR_IMM,
        S_STOP
    } seq_state_e;

    function automatic logic [7:0] dev_with_dir(input logic [7:0] dev, input logic rd);
        return {dev[7:1], rd};
    endfunction

endpackage

// File: rtl/xfer_ticker.sv
module xfer_ticker #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            tick_q <= (cnt_q == LAST);
        end
    end

    assign tick = tick_q && run;
endmodule

// File: rtl/xfer_subaddr.sv
module xfer_subaddr #(
    parameter int NB = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [$clog2(NB+1)-1:0]      len_in,
    input  logic [8*NB-1:0]              addr_in,
    input  logic                         advance,
    output logic [7:0]                   byte_o,
    output logic                         last_o,
    output logic                         empty_o
);
    localparam int LW = $clog2(NB + 1);
    localparam int SW = 8 * NB;

    logic [SW-1:0] shreg_q;
    logic [LW-1:0] left_q;
    logic [LW-1:0] len_c;

    assign len_c = (len_in > LW'(NB)) ? LW'(NB) : len_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            left_q  <= '0;
        end else if (load) begin
            shreg_q <= addr_in << (8 * (NB - int'(len_c)));
            left_q  <= len_c;
        end else if (advance && left_q != '0) begin
            shreg_q <= shreg_q << 8;
            left_q  <= left_q - 1'b1;
        end
    end

    assign byte_o  = shreg_q[SW-1 -: 8];
    assign last_o  = (left_q == LW'(1));
    assign empty_o = (left_q == '0);
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
    import i2c_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [7:0]       req_dev,
    input  logic [CNT_W-1:0] req_count,
    input  logic [7:0]       req_imm,
    output logic             req_taken,
    input  logic [7:0]       sub_byte,
    input  logic             sub_last,
    input  logic             sub_empty,
    output logic             sub_load,
    output logic             sub_adv,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             op_valid,
    output bus_op_e          op_code,
    output logic [7:0]       op_byte,
    input  logic             op_done,
    input  logic             op_nack,
    input  logic [7:0]       op_rdata,
    output logic             busy,
    output logic             error,
    output logic             tx_done,
    output logic             rx_done,
    output logic             err_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    seq_state_e       state_q, state_d, after_sub;
    logic             is_rd_q, busy_q, error_q, abort_q;
    logic [7:0]       dev_q, imm_q, dbuf_q;
    logic [CNT_W-1:0] left_q;
    logic             accept, nack_abort;
    logic             tx_q, rx_q, er_q;

    assign accept    = req_valid && !busy_q;
    assign req_taken = accept;
    assign sub_load  = accept;
    assign after_sub = is_rd_q ? S_RESTART : ((left_q == '0) ? S_WR_IMM : S_WR_FETCH);

    always_comb begin
        state_d    = state_q;
        op_valid   = 1'b0;
        op_code    = OP_NONE;
        op_byte    = 8'h00;
        wr_ready   = 1'b0;
        rd_valid   = 1'b0;
        sub_adv    = 1'b0;
        nack_abort = 1'b0;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_START;
            S_START: begin
                op_valid = 1'b1;
                op_code  = OP_START;
                if (op_done) state_d = S_DEV_WR;
            end
            S_DEV_WR: begin
                op_valid = 1'b1;
                op_code  = OP_WRITE;
                op_byte  = dev_with_dir(dev_q, 1'b0);
                if (op_done) begin
                    nack_abort = op_nack;
                    if (op_nack)         state_d = S_STOP;
                    else if (!sub_empty) state_d = S_SUB;
                    else                 state_d = after_sub;
                end
            end
            S_SUB: begin
                op_valid = 1'b1;
                op_code  = OP_WRITE;
                op_byte  = sub_byte;
                if (op_done) begin
                    sub_adv    = 1'b1;
                    nack_abort = op_nack;
                    if (op_nack)       state_d = S_STOP;
                    else if (sub_last) state_d = after_sub;
                end
            end
            S_RESTART: begin
                op_valid = 1'b1;
                op_code  = OP_RESTART;
                if (op_done) state_d = S_DEV_RD;
            end
            S_DEV_RD: begin
                op_valid = 1'b1;
                op_code  = OP_WRITE;
                op_byte  = dev_with_dir(dev_q, 1'b1);
                if (op_done) begin
                    nack_abort = op_nack;
                    state_d    = op_nack ? S_STOP : S_RD;
                end
            end
            S_RD: begin
                op_valid = 1'b1;
                op_code  = (left_q == ONE) ? OP_RD_NACK : OP_RD_ACK;
                if (op_done) state_d = S_RD_PUSH;
            end
            S_RD_PUSH: begin
                rd_valid = 1'b1;
                if (rd_ready) state_d = (left_q == ONE) ? S_STOP : S_RD;
            end
            S_WR_FETCH: begin
                wr_ready = 1'b1;
                if (wr_valid) state_d = S_WR_DATA;
            end
            S_WR_DATA: begin
                op_valid = 1'b1;
                op_code  = OP_WRITE;
                op_byte  = dbuf_q;
                if (op_done) begin
                    nack_abort = op_nack;
                    if (op_nack || left_q == ONE) state_d = S_STOP;
                    else                          state_d = S_WR_FETCH;
                end
            end
            S_WR_IMM: begin
                op_valid = 1'b1;
                op_code  = OP_WRITE;
                op_byte  = imm_q;
                if (op_done) begin
                    nack_abort = op_nack;
                    state_d    = S_STOP;
                end
            end
            S_STOP: begin
                op_valid = 1'b1;
                op_code  = OP_STOP;
                if (op_done) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            is_rd_q <= 1'b0;
            busy_q  <= 1'b0;
            error_q <= 1'b0;
            abort_q <= 1'b0;
            dev_q   <= '0;
            imm_q   <= '0;
            dbuf_q  <= '0;
            left_q  <= '0;
            tx_q    <= 1'b0;
            rx_q    <= 1'b0;
            er_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            tx_q    <= 1'b0;
            rx_q    <= 1'b0;
            er_q    <= 1'b0;
            if (accept) begin
                is_rd_q <= req_read;
                dev_q   <= req_dev;
                imm_q   <= req_imm;
                left_q  <= (req_read && req_count == '0) ? ONE : req_count;
                busy_q  <= 1'b1;
                error_q <= 1'b0;
                abort_q <= 1'b0;
            end
            if (nack_abort) abort_q <= 1'b1;
            if (state_q == S_RD && op_done)          dbuf_q <= op_rdata;
            if (state_q == S_WR_FETCH && wr_valid)   dbuf_q <= wr_data;
            if (state_q == S_RD_PUSH && rd_ready)    left_q <= left_q - 1'b1;
            if (state_q == S_WR_DATA && op_done && !op_nack) left_q <= left_q - 1'b1;
            if (state_q == S_STOP && op_done) begin
                busy_q  <= 1'b0;
                error_q <= abort_q;
                er_q    <= abort_q;
                rx_q    <= !abort_q && is_rd_q;
                tx_q    <= !abort_q && !is_rd_q;
            end
        end
    end

    assign busy      = busy_q;
    assign error     = error_q;
    assign rd_data   = dbuf_q;
    assign tx_done   = tx_q;
    assign rx_done   = rx_q;
    assign err_pulse = er_q;
endmodule

// File: rtl/i2c_reg_sequencer.sv
module i2c_reg_sequencer
    import i2c_seq_pkg::*;
#(
    parameter int SUB_BYTES = 4,
    parameter int CNT_W     = 8,
    parameter int TICK_DIV  = 4,
    localparam int SUB_W    = 8 * SUB_BYTES,
    localparam int LEN_W    = $clog2(SUB_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_read,
    input  logic [7:0]       req_dev,
    input  logic [SUB_W-1:0] req_sub,
    input  logic [LEN_W-1:0] req_sub_len,
    input  logic [CNT_W-1:0] req_count,
    input  logic [7:0]       req_imm,
    output logic             req_taken,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             tick_run,
    output logic             bus_tick,
    output logic             op_valid,
    output logic [2:0]       op_code,
    output logic [7:0]       op_byte,
    input  logic             op_done,
    input  logic             op_nack,
    input  logic [7:0]       op_rdata,
    output logic             busy,
    output logic             error,
    output logic             tx_done,
    output logic             rx_done,
    output logic             err_pulse
);
    logic       sub_load, sub_adv, sub_last, sub_empty;
    logic [7:0] sub_byte;
    bus_op_e    op_kind;

    xfer_subaddr #(.NB(SUB_BYTES)) u_sub (
        .clk     (clk),
        .rst     (rst),
        .load    (sub_load),
        .len_in  (req_sub_len),
        .addr_in (req_sub),
        .advance (sub_adv),
        .byte_o  (sub_byte),
        .last_o  (sub_last),
        .empty_o (sub_empty)
    );

    xfer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_read  (req_read),
        .req_dev   (req_dev),
        .req_count (req_count),
        .req_imm   (req_imm),
        .req_taken (req_taken),
        .sub_byte  (sub_byte),
        .sub_last  (sub_last),
        .sub_empty (sub_empty),
        .sub_load  (sub_load),
        .sub_adv   (sub_adv),
        .wr_data   (wr_data),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .op_valid  (op_valid),
        .op_code   (op_kind),
        .op_byte   (op_byte),
        .op_done   (op_done),
        .op_nack   (op_nack),
        .op_rdata  (op_rdata),
        .busy      (busy),
        .error     (error),
        .tx_done   (tx_done),
        .rx_done   (rx_done),
        .err_pulse (err_pulse)
    );

    assign op_code  = op_kind;
    assign tick_run = busy;

    xfer_ticker #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (tick_run),
        .tick (bus_tick)
    );
endmodule

// File: rtl/i2c_seq_checker.sv
module i2c_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       busy,
    input logic       error,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic [7:0] op_byte,
    input logic       op_done,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       tx_done,
    input logic       rx_done,
    input logic       err_pulse
);
    // R1 R12
    accept_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (busy && !error));

    // R11
    op_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> busy);

    // R11
    op_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_done) |=> (op_valid && $stable(op_code) && $stable(op_byte)));

    // R9
    done_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done || rx_done) |-> (!busy && !error));

    // R8
    abort_flag_chk: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (error && !busy));

    // R9
    one_end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_done, rx_done, err_pulse}));

    // R7
    wr_wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (busy && !op_valid));

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind i2c_reg_sequencer i2c_seq_checker u_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .error     (error),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_byte   (op_byte),
    .op_done   (op_done),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .err_pulse (err_pulse)
);

// File: tb/test_i2c_reg_sequencer.sv
module test_i2c_reg_sequencer;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_read = 1'b0;
    logic [7:0]  req_dev = '0, req_imm = '0, req_count = '0;
    logic [31:0] req_sub = '0;
    logic [2:0]  req_sub_len = '0;
    logic        req_taken;
    logic [7:0]  wr_data = '0;
    logic        wr_valid = 1'b0, wr_ready;
    logic [7:0]  rd_data;
    logic        rd_valid, rd_ready = 1'b0;
    logic        tick_run, bus_tick;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [7:0]  op_byte;
    logic        op_done = 1'b0, op_nack = 1'b0;
    logic [7:0]  op_rdata = '0;
    logic        busy, error, tx_done, rx_done, err_pulse;

    always #5 clk = ~clk;

    i2c_reg_sequencer #(.TICK_DIV(DIV)) i_i2c_reg_sequencer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
        .req_dev(req_dev), .req_sub(req_sub), .req_sub_len(req_sub_len),
        .req_count(req_count), .req_imm(req_imm), .req_taken(req_taken),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .tick_run(tick_run), .bus_tick(bus_tick), .op_valid(op_valid),
        .op_code(op_code), .op_byte(op_byte), .op_done(op_done),
        .op_nack(op_nack), .op_rdata(op_rdata), .busy(busy), .error(error),
        .tx_done(tx_done), .rx_done(rx_done), .err_pulse(err_pulse)
    );

    int checks = 0, errors = 0;
    int cyc = 0, last_tick = -1, idle_ticks = 0, gap_bad = 0;
    int nlog = 0, nack_at = -1, nrd = 0, widx = 0;
    int tx_n = 0, rx_n = 0, er_n = 0;
    bit stall = 0, hs_pend = 0;
    logic [2:0] log_code [64];
    logic [7:0] log_byte [64];
    logic [7:0] rlog [64];
    logic [2:0] ecode [64];
    logic [7:0] ebyte [64];
    int ne;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // bus engine model, write and read stream drivers, monitors
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (rst) begin
                op_done = 0;
            end else begin
                if (op_done) op_done = 0;
                else if (op_valid && bus_tick) begin
                    if (nlog < 64) begin
                        log_code[nlog] = op_code;
                        log_byte[nlog] = op_byte;
                    end
                    op_nack  = (nlog == nack_at);
                    op_rdata = 8'h5A ^ nlog[7:0];
                    nlog++;
                    op_done = 1;
                end
                if (hs_pend) widx++;
                wr_valid = stall ? (cyc % 3 == 0) : 1'b1;
                wr_data  = 8'h30 + widx[7:0];
                hs_pend  = wr_valid && wr_ready;
                rd_ready = stall ? (cyc % 2 == 0) : 1'b1;
                if (rd_valid && rd_ready) begin
                    if (nrd < 64) rlog[nrd] = rd_data;
                    nrd++;
                end
                if (tx_done) tx_n++;
                if (rx_done) rx_n++;
                if (err_pulse) er_n++;
                if (bus_tick && !tick_run) idle_ticks++;
                if (!tick_run) last_tick = -1;
                else if (bus_tick) begin
                    if (last_tick >= 0 && cyc - last_tick != DIV) gap_bad++;
                    last_tick = cyc;
                end
            end
        end
    end

    task automatic push(input logic [2:0] c, input logic [7:0] b);
        ecode[ne] = c;
        ebyte[ne] = b;
        ne++;
    endtask

    task automatic run_txn(input bit rd, input logic [7:0] dev, input logic [31:0] sub,
                           input int len, input int cnt, input logic [7:0] imm,
                           input int nk, input bit stl);
        int w0, l, n, t, bad, rexp, rgot;
        string tag;
        @(negedge clk); #1;
        nlog = 0; nrd = 0; nack_at = nk; stall = stl; w0 = widx;
        tx_n = 0; rx_n = 0; er_n = 0;
        req_read = rd; req_dev = dev; req_sub = sub; req_sub_len = len[2:0];
        req_count = cnt[7:0]; req_imm = imm; req_valid = 1;
        #1;
        chk(req_taken === 1'b1, "R1", "taken when idle", req_taken, 1);
        @(negedge clk); #1;
        chk(busy === 1'b1 && tick_run === 1'b1, "R10", "busy/tick_run after accept", {busy, tick_run}, 3);
        chk(error === 1'b0, "R12", "error cleared on accept", error, 0);
        req_read = !rd; req_count = 8'd9; #1;
        chk(req_taken === 1'b0, "R1", "taken while busy", req_taken, 0);
        @(negedge clk); #1;
        req_valid = 0;
        t = 0;
        while (busy && t < 20000) begin @(negedge clk); t++; end
        if (busy) chk(0, "R9", "transaction hang", t, 0);
        @(negedge clk); #1;
        // expected operation list
        l = (len > 4) ? 4 : len;
        n = (rd && cnt == 0) ? 1 : cnt;
        ne = 0;
        push(3'd1, 8'h00);
        push(3'd3, {dev[7:1], 1'b0});
        for (int k = 0; k < l; k++) push(3'd3, 8'(sub >> (8 * (l - 1 - k))));
        if (rd) begin
            push(3'd2, 8'h00);
            push(3'd3, {dev[7:1], 1'b1});
            for (int k = 0; k < n; k++) push((k == n - 1) ? 3'd5 : 3'd4, 8'h00);
        end else if (cnt == 0) push(3'd3, imm);
        else for (int k = 0; k < n; k++) push(3'd3, 8'(w0 + k + 8'h30));
        if (nk >= 0) ne = nk + 1;
        push(3'd6, 8'h00);
        tag = rd ? "R4" : (cnt == 0 ? "R6" : "R7");
        if (nk >= 0) tag = "R8";
        else if (l > 0) tag = {tag, "/R3"};
        bad = (nlog != ne);
        for (int k = 0; k < ne && k < nlog; k++)
            if (log_code[k] !== ecode[k] || (ecode[k] == 3'd3 && log_byte[k] !== ebyte[k])) begin
                if (!bad) $display("FAIL %s R2 op %0d: actual %0h/%0h expected %0h/%0h",
                                   tag, k, log_code[k], log_byte[k], ecode[k], ebyte[k]);
                bad = 1;
            end
        chk(!bad, tag, "operation count", nlog, ne);
        // read data stream
        rexp = 0; rgot = nrd; bad = 0;
        for (int k = 0; k < ne; k++)
            if (ecode[k] == 3'd4 || ecode[k] == 3'd5) begin
                if (rexp >= nrd || rlog[rexp] !== (8'h5A ^ k[7:0])) bad = 1;
                rexp++;
            end
        chk(!bad && rgot == rexp, "R5", "read stream bytes", rgot, rexp);
        if (nk >= 0) begin
            chk(er_n == 1 && tx_n == 0 && rx_n == 0, "R8", "abort pulses", {er_n, tx_n, rx_n}, 1 << 2);
            chk(error === 1'b1, "R8", "error flag", error, 1);
        end else begin
            chk(er_n == 0 && tx_n == (rd ? 0 : 1) && rx_n == (rd ? 1 : 0), "R9", "done pulses",
                {er_n, tx_n, rx_n}, rd ? 1 : 2);
            chk(error === 1'b0 && busy === 1'b0, "R9", "flags after done", {busy, error}, 0);
        end
        chk(idle_ticks == 0 && gap_bad == 0 && tick_run === 1'b0, "R10", "tick pacing",
            idle_ticks + gap_bad, 0);
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int idx;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk); #1;
        chk(busy === 0 && error === 0 && op_valid === 0 && wr_ready === 0 && rd_valid === 0 && tick_run === 0,
            "R9", "reset state", {busy, error, op_valid, wr_ready, rd_valid, tick_run}, 0);
        repeat (10) @(negedge clk);
        chk(idle_ticks == 0, "R10", "no tick while idle", idle_ticks, 0);
        // direction x sub-address length x count sweep
        idx = 0;
        for (int rd = 0; rd < 2; rd++)
            for (int len = 0; len <= 4; len++)
                for (int cnt = 0; cnt < 4; cnt++) begin
                    run_txn(rd[0], 8'h51 + 8'(2 * idx), 32'hC1B2A394, len, cnt, 8'hE0 + 8'(idx), -1, idx[0]);
                    idx++;
                end
        // oversize length behaves as four, longer bursts
        run_txn(1'b0, 8'h3B, 32'h11223344, 7, 2, 8'h00, -1, 1'b0);
        run_txn(1'b0, 8'h6C, 32'h0000BEEF, 2, 9, 8'h00, -1, 1'b1);
        run_txn(1'b1, 8'h6D, 32'h00000077, 1, 7, 8'h00, -1, 1'b1);
        // NACK on every write position: write, 2-byte sub-address, 2 data bytes
        for (int k = 1; k <= 5; k++) run_txn(1'b0, 8'hA1, 32'h0000F00D, 2, 2, 8'h00, k, k[0]);
        // NACK on immediate byte
        run_txn(1'b0, 8'hA1, 32'h00000012, 1, 0, 8'h99, 3, 1'b0);
        // NACK on read: device write, sub-address, device read
        run_txn(1'b1, 8'hA3, 32'h00000045, 1, 2, 8'h00, 1, 1'b0);
        run_txn(1'b1, 8'hA3, 32'h00000045, 1, 2, 8'h00, 2, 1'b1);
        run_txn(1'b1, 8'hA3, 32'h00000045, 1, 2, 8'h00, 4, 1'b0);
        // recovery after an abort clears the error flag
        run_txn(1'b1, 8'hA3, 32'h00000045, 0, 1, 8'h00, -1, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule